// File: doc/BRIEF.md
# EEPROM Page Write and Protection Controller

This block sits between the serial command front end of a small EEPROM and its storage array. The front end tells it when a write command begins and gives it the start address. It then passes each received data byte and reports the rise of chip select, together with a flag saying whether that rise fell exactly on a byte boundary. The controller gathers up to one page of bytes in a local buffer. It decides whether the write may proceed, based on the write-enable latch, the write-protect input and the block-protection level. It then runs a self-timed programming cycle. During that cycle it moves the buffered bytes into the array and holds a busy flag.

The same timed cycle is used for status-register writes, which change the two-bit block-protection level. The write-enable latch is set and cleared by single-cycle requests, and it clears itself when any programming cycle ends. A parameterised cycle count models the programming time.

Top module: `eep_page_prog`

## Requirements
- R1: `wren_req` sets `wel` only when `wp_n` is high and `busy` is low. `wrdi_req` clears `wel` whenever `busy` is low, with or without `wp_n`.
- R2: Each data byte goes to page slot (start address low 3 bits + byte index) mod 8, and the upper address bits stay fixed. A ninth or later byte replaces the byte stored earlier in the same slot.
- R3: A collected write is programmed only if `cs_rise` arrives with `cs_aligned` high and at least one byte received. Otherwise the write is discarded: `busy` stays low and the array is not touched.
- R4: A write that starts while `wel` is 0 or `wp_n` is low is discarded, and `wel` keeps its value.
- R5: If `wp_n` goes low at any cycle while bytes are being collected, the write is aborted. If `wp_n` goes low after `busy` has risen, the programming still completes.
- R6: No array byte is written where `bp` protects it. With a 9-bit address: `bp`=0 protects nothing, `bp`=1 protects 0x180-0x1FF, `bp`=2 protects 0x100-0x1FF, and `bp`=3 protects every address.
- R7: `sr_req` starts a status write only when `wel`=1 and `wp_n`=1. `bp` takes the value of `sr_bp` when that cycle ends, and never at any other time.
- R8: `busy` rises in the cycle after an accepted `cs_rise` or `sr_req`. It stays high for PAGE_BYTES+TWC_CYCLES cycles for an array write and TWC_CYCLES cycles for a status write. `wel` is 0 once `busy` falls.
- R9: While `busy` is high, `wren_req`, `wrdi_req`, `wr_start` and `sr_req` are ignored, and `wel` stays 1.
- R10: Page slots that received no byte are left unchanged in the array. `mem_we` pulses only for slots that received a byte and are not protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wp_n | input | 1 | Write-protect input, low inhibits writes |
| wren_req | input | 1 | Set write-enable latch request |
| wrdi_req | input | 1 | Clear write-enable latch request |
| wr_start | input | 1 | Array write command begins |
| wr_addr | input | ADDR_W | Start address of the write |
| byte_vld | input | 1 | A data byte is present |
| byte_dat | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select has risen |
| cs_aligned | input | 1 | The rise came right after a complete byte |
| sr_req | input | 1 | Status write, sampled at chip-select rise |
| sr_bp | input | 2 | New protection level |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Programming cycle in progress (ready flag, inverted) |
| wel | output | 1 | Write-enable latch |
| bp | output | 2 | Current protection level |

## Verification
The hardest situations to reach are those where several gates line up in one write. Examples are a page stream longer than eight bytes that starts mid-page and ends in a protected quarter, or a one-cycle drop of `wp_n` in the middle of collection. Directed cases build each of these on purpose. Random operations then mix enables, status writes with random levels, start addresses and lengths up to twelve bytes, misaligned chip-select rises and short protect glitches. A bench model predicts the array contents, `wel`, `bp` and the exact busy length for every sequence.

// File: rtl/eep_page_prog.sv
module eep_page_prog #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 8,
  parameter int TWC_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              wren_req,
  input  logic              wrdi_req,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_vld,
  input  logic [7:0]        byte_dat,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              sr_req,
  input  logic [1:0]        sr_bp,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              wel,
  output logic [1:0]        bp
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - SLOT_W;
  localparam int CNT_W  = $clog2(TWC_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_PROG, S_WAIT} state_t;

  state_t                 state;
  logic                   armed, is_sr;
  logic [1:0]             bp_next;
  logic [PAGE_W-1:0]      page_q;
  logic [SLOT_W-1:0]      ptr_q, slot_q;
  logic [PAGE_BYTES-1:0]  mask_q;
  logic [7:0]             buf_q [PAGE_BYTES];
  logic [CNT_W-1:0]       cnt_q;

  function automatic logic in_prot(input logic [ADDR_W-1:0] a, input logic [1:0] lvl);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return &a[ADDR_W-1:ADDR_W-2];
      2'd2:    return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction

  assign busy      = (state == S_PROG) || (state == S_WAIT);
  assign mem_addr  = {page_q, slot_q};
  assign mem_wdata = buf_q[slot_q];
  assign mem_we    = (state == S_PROG) && mask_q[slot_q] && !in_prot(mem_addr, bp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      wel     <= 1'b0;
      bp      <= 2'd0;
      bp_next <= 2'd0;
      is_sr   <= 1'b0;
      armed   <= 1'b0;
      page_q  <= '0;
      ptr_q   <= '0;
      slot_q  <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (wrdi_req)             wel <= 1'b0;
          else if (wren_req && wp_n) wel <= 1'b1;
          if (wr_start) begin
            page_q <= wr_addr[ADDR_W-1:SLOT_W];
            ptr_q  <= wr_addr[SLOT_W-1:0];
            mask_q <= '0;
            armed  <= wel && wp_n;
            state  <= S_FILL;
          end else if (sr_req && wel && wp_n) begin
            bp_next <= sr_bp;
            is_sr   <= 1'b1;
            cnt_q   <= CNT_W'(TWC_CYCLES - 1);
            state   <= S_WAIT;
          end
        end
        S_FILL: begin
          if (!wp_n) armed <= 1'b0;
          if (byte_vld) begin
            buf_q[ptr_q]  <= byte_dat;
            mask_q[ptr_q] <= 1'b1;
            ptr_q         <= ptr_q + 1'b1;
          end
          if (cs_rise) begin
            if (armed && wp_n && cs_aligned && (|mask_q)) begin
              slot_q <= '0;
              is_sr  <= 1'b0;
              state  <= S_PROG;
            end else begin
              state  <= S_IDLE;
            end
          end
        end
        S_PROG: begin
          slot_q <= slot_q + 1'b1;
          if (slot_q == SLOT_W'(PAGE_BYTES - 1)) begin
            cnt_q <= CNT_W'(TWC_CYCLES - 1);
            state <= S_WAIT;
          end
        end
        default: begin
          if (cnt_q == '0) begin
            state <= S_IDLE;
            wel   <= 1'b0;
            if (is_sr) bp <= bp_next;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R8
  AST_WEL_CLEAR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel); // R8
  AST_WEL_SET_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> ($past(wp_n) && !$past(busy))); // R1
  AST_BP_CHANGE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $fell(busy)); // R7
  AST_WEL_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wel); // R9
  AST_NO_PROT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && bp == 2'd3) |-> 1'b0); // R6
endmodule

// File: tb/test_eep_page_prog.sv
`timescale 1ns/1ps
module test_eep_page_prog;
  localparam int AW  = 9;
  localparam int PB  = 8;
  localparam int TWC = 20;
  localparam int NA  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wp_n = 1'b1, wren_req = 1'b0, wrdi_req = 1'b0, wr_start = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic byte_vld = 1'b0, cs_rise = 1'b0, cs_aligned = 1'b0, sr_req = 1'b0;
  logic [7:0] byte_dat = '0;
  logic [1:0] sr_bp = '0;
  logic mem_we, busy, wel;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [1:0] bp;

  always #2.5 clk = ~clk;

  eep_page_prog #(.ADDR_W(AW), .PAGE_BYTES(PB), .TWC_CYCLES(TWC)) i_eep_page_prog (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wren_req(wren_req), .wrdi_req(wrdi_req),
    .wr_start(wr_start), .wr_addr(wr_addr), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .cs_rise(cs_rise), .cs_aligned(cs_aligned), .sr_req(sr_req), .sr_bp(sr_bp),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .wel(wel), .bp(bp));

  logic [7:0] arr [NA];
  logic [7:0] exp_arr [NA];
  logic wel_m = 1'b0;
  logic [1:0] bp_m = 2'd0;
  int nchk = 0, nfail = 0;

  always @(posedge clk) if (mem_we) arr[mem_addr] <= mem_wdata;

  function automatic logic prot_m(input int a, input logic [1:0] lvl);
    case (lvl)
      2'd0: return 1'b0;
      2'd1: return a >= 'h180;
      2'd2: return a >= 'h100;
      default: return 1'b1;
    endcase
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic check(input string tag, input int act, input int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic mem_compare(input string tag);
    int bad = 0;
    for (int i = 0; i < NA; i++) if (arr[i] !== exp_arr[i]) bad++;
    check(tag, bad, 0);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; tick(); end
  endtask

  task automatic do_wren(); wren_req = 1'b1; tick(); wren_req = 1'b0;
    if (wp_n) wel_m = 1'b1; endtask
  task automatic do_wrdi(); wrdi_req = 1'b1; tick(); wrdi_req = 1'b0; wel_m = 1'b0; endtask

  // glitch: byte index at which wp_n drops for one cycle (-1 none); wp_busy: drop wp_n during busy
  task automatic do_write(input int addr, input int n, input bit aligned, input int glitch,
                          input bit wp_busy, input string tag);
    logic [7:0] pbuf [PB];
    bit pmask [PB];
    bit ok;
    int cnt;
    for (int i = 0; i < PB; i++) pmask[i] = 0;
    ok = wel_m && wp_n && aligned && (n > 0) && (glitch < 0 || glitch < n);
    if (glitch >= n) ok = wel_m && wp_n && aligned && (n > 0);
    if (glitch >= 0 && glitch < n) ok = 1'b0;
    wr_addr = AW'(addr); wr_start = 1'b1; tick(); wr_start = 1'b0;
    for (int k = 0; k < n; k++) begin
      int s = ((addr % PB) + k) % PB;
      byte_dat = 8'($urandom); byte_vld = 1'b1;
      pbuf[s] = byte_dat; pmask[s] = 1;
      if (k == glitch) wp_n = 1'b0;
      tick();
      wp_n = 1'b1; byte_vld = 1'b0;
    end
    cs_rise = 1'b1; cs_aligned = aligned; tick(); cs_rise = 1'b0; cs_aligned = 1'b0;
    if (ok) begin
      if (wp_busy) wp_n = 1'b0;
      count_busy(cnt);
      wp_n = 1'b1;
      check({tag, " R8 busy length"}, cnt, PB + TWC);
      for (int s = 0; s < PB; s++) begin
        int a = (addr / PB) * PB + s;
        if (pmask[s] && !prot_m(a, bp_m)) exp_arr[a] = pbuf[s];
      end
      wel_m = 1'b0;
    end else begin
      check({tag, " busy stays low"}, int'(busy), 0);
    end
    check({tag, " wel"}, int'(wel), int'(wel_m));
  endtask

  task automatic do_wrsr(input logic [1:0] v, input string tag);
    int cnt;
    bit ok = wel_m && wp_n;
    sr_bp = v; sr_req = 1'b1; tick(); sr_req = 1'b0;
    if (ok) begin
      check({tag, " R7 bp held during cycle"}, int'(bp), int'(bp_m));
      count_busy(cnt);
      check({tag, " R8 status busy length"}, cnt, TWC);
      bp_m = v; wel_m = 1'b0;
    end else check({tag, " busy stays low"}, int'(busy), 0);
    check({tag, " bp"}, int'(bp), int'(bp_m));
    check({tag, " wel"}, int'(wel), int'(wel_m));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < NA; i++) begin arr[i] = 8'(i ^ 'h5A); exp_arr[i] = 8'(i ^ 'h5A); end
    repeat (3) tick();
    rst_n = 1'b1; tick();
    check("reset busy", int'(busy), 0);
    check("reset wel", int'(wel), 0);
    check("reset bp", int'(bp), 0);
    check("reset mem_we", int'(mem_we), 0);

    // R1: enable gated by wp_n; disable ignores wp_n
    wp_n = 1'b0; do_wren(); check("R1 wren with wp low", int'(wel), 0);
    wp_n = 1'b1; do_wren(); check("R1 wren sets", int'(wel), 1);
    wp_n = 1'b0; do_wrdi(); wp_n = 1'b1; check("R1 wrdi clears", int'(wel), 0);

    // R4: write without latch, and with wp low at start
    do_write('h010, 3, 1, -1, 0, "R4 no wel"); mem_compare("R4 no wel array");
    do_wren(); wp_n = 1'b0;
    wr_addr = 'h020; wr_start = 1'b1; tick(); wr_start = 1'b0; wp_n = 1'b1;
    byte_dat = 8'hAA; byte_vld = 1'b1; tick(); byte_vld = 1'b0;
    cs_rise = 1'b1; cs_aligned = 1'b1; tick(); cs_rise = 1'b0; cs_aligned = 1'b0;
    check("R4 wp low at start busy", int'(busy), 0);
    check("R4 wel kept", int'(wel), 1);
    mem_compare("R4 wp low array");

    // R2 + R10: start mid-page, 11 bytes wrap; partial page leaves others
    do_write('h03D, 11, 1, -1, 0, "R2 wrap"); mem_compare("R2 wrap array");
    do_wren(); do_write('h042, 2, 1, -1, 0, "R10 partial"); mem_compare("R10 partial array");

    // R3: misaligned rise discards
    do_wren(); do_write('h050, 4, 0, -1, 0, "R3 misaligned"); mem_compare("R3 array");

    // R5: glitch during collect aborts; wp low during busy has no effect
    do_write('h060, 5, 1, 2, 0, "R5 glitch"); mem_compare("R5 glitch array");
    do_write('h068, 5, 1, -1, 1, "R5 wp in busy"); mem_compare("R5 busy array");

    // R7: status write without wel ignored; then each level with R6 checks
    do_wrsr(2'd2, "R7 no wel");
    for (int lv = 1; lv < 4; lv++) begin
      do_wren(); do_wrsr(2'(lv), "R7 set");
      do_wren(); do_write('h17C, 8, 1, -1, 0, "R6 edge page");
      do_wren(); do_write('h0FC, 8, 1, -1, 0, "R6 half edge");
      do_wren(); do_write('h1F8, 8, 1, -1, 0, "R6 top page");
      mem_compare("R6 protection array");
    end
    do_wren(); do_wrsr(2'd0, "R7 clear");

    // R9: commands during busy ignored
    do_wren();
    wr_addr = 'h0A0; wr_start = 1'b1; tick(); wr_start = 1'b0;
    byte_dat = 8'h3C; byte_vld = 1'b1; tick(); byte_vld = 1'b0;
    cs_rise = 1'b1; cs_aligned = 1'b1; tick(); cs_rise = 1'b0; cs_aligned = 1'b0;
    exp_arr['h0A0] = 8'h3C;
    wrdi_req = 1'b1; tick(); wrdi_req = 1'b0;
    check("R9 wel held after wrdi in busy", int'(wel), 1);
    sr_bp = 2'd3; sr_req = 1'b1; tick(); sr_req = 1'b0;
    wr_addr = 'h0B0; wr_start = 1'b1; tick(); wr_start = 1'b0;
    check("R9 still busy", int'(busy), 1);
    count_busy(cnt); wel_m = 1'b0;
    repeat (3) tick();
    check("R9 bp unchanged", int'(bp), 0);
    check("R9 busy idle after", int'(busy), 0);
    check("R8 wel cleared", int'(wel), 0);
    mem_compare("R9 array");

    // random mix
    for (int it = 0; it < 200; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) do_wren();
      else if (op == 3) do_wrdi();
      else if (op == 4) do_wrsr(2'($urandom_range(0, 3)), "R7 rand");
      else do_write($urandom_range(0, NA - 1), $urandom_range(1, 12),
                    ($urandom_range(0, 5) != 0), ($urandom_range(0, 5) == 0) ? $urandom_range(0, 11) : -1,
                    ($urandom_range(0, 3) == 0), "R2 rand");
    end
    mem_compare("R6 R10 random array");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule